// File: doc/BRIEF.md
# Reservation Tag Array

This block is the tag store of a non-blocking, read-only set-associative cache. Every line holds a tag, the block address it caches, three timestamps and a state: empty, pending (space claimed, data still on its way from memory) or valid. The data itself is kept elsewhere. A second level that tracks outstanding misses sits beside this array and drives its fill inputs when data returns.

The block has three ports. The lookup port is purely combinational: it reports where an address would land, either the way that holds it or the way that would be evicted for it. The access port does the same lookup and also records the result: it refreshes recency on hits and, when allocation happens at miss time, claims the victim way for the incoming block. Two fill inputs complete a line. One names the line directly by its index. The other names it by block address, for the configuration where space is only chosen when the data arrives. A flush input clears every line in one cycle.

Victim choice is set by a parameter. It is either least recently used or first in, first out. Three counters record accesses, misses, and misses that landed on a pending line.

Top module: `cta_tag_array`

## Requirements
- R1: For a line of 2^O bytes and 2^S sets, the set index is address bits [O+S-1:O] and the tag is every address bit from O+S upward. The block address stored in a line is the access address with its low O bits cleared.
- R2: After reset, every line is empty: any lookup returns MISS with way 0, and all three counters read 0.
- R3: The status code is 0 (HIT) when the tag matches a valid way, 1 (HIT_PENDING) when it matches a pending way, 2 (MISS) when no way matches, and 3 (FAIL) when no way matches and every way of the set is pending.
- R4: A lookup on the probe port changes no line and no counter, however long it is held.
- R5: With allocation at miss time, an access that returns MISS claims the reported way. The way stores the tag and block address and becomes pending, so later lookups of that address return HIT_PENDING on that way.
- R6: A fill by index, where the index is set*WAYS + way, turns a pending line valid. The probe port then shows the cycle of the fill (the number of clock cycles since reset) and the stored block address.
- R7: On a miss, the reported way is the lowest-numbered empty way. If there is none, it is the valid way with the smallest stamp: the last access time in LRU mode, or the allocation time in FIFO mode. Hits and pending hits refresh the last access time. Pending ways are never chosen.
- R8: An access that returns FAIL changes no line.
- R9: With allocation at fill time, an access miss claims nothing. A fill by address makes the line valid at the way a lookup would report, recording the tag, block address and fill time. A fill by address of a block that is already valid changes nothing.
- R10: Each access adds 1 to the access counter. Any status other than HIT adds 1 to the miss counter, and HIT_PENDING also adds 1 to the pending counter.
- R11: A flush empties every line in one cycle and leaves the counters unchanged. Flush, fill by index, fill by address and access are issued at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_addr | input | ADDR_W | Address for the side-effect-free lookup |
| probe_set | output | SET_W | Set index of probe_addr |
| probe_tag | output | TAG_W | Tag of probe_addr |
| probe_status | output | 2 | Lookup status for probe_addr |
| probe_way | output | WAY_W | Hit way or victim way for probe_addr |
| probe_blk | output | ADDR_W | Stored block address of the reported line |
| probe_fill_time | output | TIME_W | Stored fill time of the reported line |
| acc_valid | input | 1 | Perform an access this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_status | output | 2 | Lookup status for acc_addr |
| acc_way | output | WAY_W | Hit way or victim way for acc_addr |
| fill_idx_valid | input | 1 | Complete the line named by fill_idx |
| fill_idx | input | SET_W+WAY_W | Line index, set*WAYS + way |
| fill_addr_valid | input | 1 | Complete or install the line for fill_addr |
| fill_addr | input | ADDR_W | Address of the returning block |
| flush | input | 1 | Empty every line |
| cnt_access | output | CNT_W | Number of accesses |
| cnt_miss | output | CNT_W | Number of accesses that were not plain hits |
| cnt_pending | output | CNT_W | Number of accesses that hit a pending line |

## Verification
The embedded checks assume that the caller issues at most one of flush, fill by index, fill by address and access in any cycle. They also assume that a fill by index only names a line that is currently pending. The stimulus issues every operation in a cycle of its own. It fills by index only the lines that earlier accesses were seen to claim, and it never fills by index after a flush. Two instances cover LRU with allocation at miss time and FIFO with allocation at fill time. Expected ways, statuses and fill times are derived arithmetically from the address split and the bench's own cycle count.

// File: rtl/cta_pkg.sv
// Shared encodings for the reservation tag array.
// Assumes: nothing beyond SystemVerilog 2017 packages.
package cta_pkg;

    // Line state; PENDING means space is claimed but data has not returned.
    typedef enum logic [1:0] {
        LN_INVALID = 2'd0,
        LN_PENDING = 2'd1,
        LN_VALID   = 2'd2
    } line_st_t;

    // Lookup result code as seen on the probe and access ports.
    typedef enum logic [1:0] {
        LK_HIT      = 2'd0,
        LK_HIT_PEND = 2'd1,
        LK_MISS     = 2'd2,
        LK_FAIL     = 2'd3
    } lk_t;

endpackage

// File: rtl/cta_addr_split.sv
// Splits an address into set index and tag.
// Assumes: line size and set count are powers of two, at least two sets,
// and the tag keeps at least one bit.
module cta_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 7,
    parameter int SET_W  = 6,
    localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SET_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    // Index bits sit just above the line offset; the tag is the rest.
    assign set_idx = addr[OFF_W +: SET_W];
    assign tag     = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cta_set_lookup.sv
// Looks one tag up across the ways of a single set and picks a victim.
// Assumes: way stamps are given by the parent already selected for the
// replacement policy (last access for LRU, allocation time for FIFO).
module cta_set_lookup #(
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2,
    parameter int TAG_W  = 19,
    parameter int TIME_W = 32
) (
    input  logic [WAYS-1:0][1:0]        way_st,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][TIME_W-1:0] way_age,
    input  logic [TAG_W-1:0]            req_tag,
    output cta_pkg::lk_t                status,
    output logic [WAY_W-1:0]            way
);
    import cta_pkg::*;

    logic              hit, hit_pend, have_inv, have_val;
    logic [WAY_W-1:0]  hit_w, inv_w, val_w;
    logic [TIME_W-1:0] best;

    // Scan the ways: first tag match, first empty way, oldest valid way.
    always_comb begin
        hit      = 1'b0;
        hit_pend = 1'b0;
        hit_w    = '0;
        have_inv = 1'b0;
        inv_w    = '0;
        have_val = 1'b0;
        val_w    = '0;
        best     = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_st[w] != LN_INVALID && way_tag[w] == req_tag && !hit) begin
                hit      = 1'b1;
                hit_pend = (way_st[w] == LN_PENDING);
                hit_w    = WAY_W'(w);
            end
            if (way_st[w] == LN_INVALID && !have_inv) begin
                have_inv = 1'b1;
                inv_w    = WAY_W'(w);
            end
            if (way_st[w] == LN_VALID && (!have_val || way_age[w] < best)) begin
                have_val = 1'b1;
                val_w    = WAY_W'(w);
                best     = way_age[w];
            end
        end
    end

    // Turn the scan into a status code and the way it refers to.
    always_comb begin
        if (hit) begin
            status = hit_pend ? LK_HIT_PEND : LK_HIT;
            way    = hit_w;
        end else if (have_inv) begin
            status = LK_MISS;
            way    = inv_w;
        end else if (have_val) begin
            status = LK_MISS;
            way    = val_w;
        end else begin
            status = LK_FAIL;
            way    = '0;
        end
    end
endmodule

// File: rtl/cta_tag_array.sv
// Tag store of a read-only non-blocking cache with pending-line tracking.
// Three lookups share the storage: probe (no side effect), access, and
// fill by address. Only the line state is reset; the payload fields are
// written before any lookup can see them as live.
// Assumes: one of flush / fill by index / fill by address / access per
// cycle, and a fill by index only names a pending line.
module cta_tag_array #(
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 128,
    parameter int ADDR_W     = 32,
    parameter int TIME_W     = 32,
    parameter int CNT_W      = 32,
    parameter bit REPL_FIFO     = 1'b0,
    parameter bit ALLOC_ON_FILL = 1'b0,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int LINES  = SETS * WAYS,
    localparam int LIDX_W = SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [SET_W-1:0]  probe_set,
    output logic [TAG_W-1:0]  probe_tag,
    output logic [1:0]        probe_status,
    output logic [WAY_W-1:0]  probe_way,
    output logic [ADDR_W-1:0] probe_blk,
    output logic [TIME_W-1:0] probe_fill_time,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [1:0]        acc_status,
    output logic [WAY_W-1:0]  acc_way,
    input  logic              fill_idx_valid,
    input  logic [LIDX_W-1:0] fill_idx,
    input  logic              fill_addr_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              flush,
    output logic [CNT_W-1:0]  cnt_access,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_pending
);
    import cta_pkg::*;

    localparam int NPORT = 3;  // 0 probe, 1 access, 2 fill by address

    line_st_t          ln_st    [LINES];
    logic [TAG_W-1:0]  ln_tag   [LINES];
    logic [ADDR_W-1:0] ln_blk   [LINES];
    logic [TIME_W-1:0] ln_alloc [LINES];
    logic [TIME_W-1:0] ln_last  [LINES];
    logic [TIME_W-1:0] ln_fill  [LINES];
    logic [TIME_W-1:0] now;

    logic [ADDR_W-1:0] lk_addr   [NPORT];
    logic [SET_W-1:0]  lk_set    [NPORT];
    logic [TAG_W-1:0]  lk_tag    [NPORT];
    lk_t               lk_status [NPORT];
    logic [WAY_W-1:0]  lk_way    [NPORT];

    logic [LIDX_W-1:0] pr_line, acc_line, fa_line;
    logic [LINES-1:0]  live;

    function automatic logic [ADDR_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

    assign lk_addr[0] = probe_addr;
    assign lk_addr[1] = acc_addr;
    assign lk_addr[2] = fill_addr;

    // One address split and one set lookup per port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [WAYS-1:0][1:0]        g_st;
        logic [WAYS-1:0][TAG_W-1:0]  g_tag;
        logic [WAYS-1:0][TIME_W-1:0] g_age;

        cta_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_split (
            .addr(lk_addr[p]), .set_idx(lk_set[p]), .tag(lk_tag[p])
        );

        // Gather the ways of the addressed set, stamp chosen by policy.
        always_comb begin
            for (int w = 0; w < WAYS; w++) begin
                g_st[w]  = ln_st[{lk_set[p], WAY_W'(w)}];
                g_tag[w] = ln_tag[{lk_set[p], WAY_W'(w)}];
                g_age[w] = REPL_FIFO ? ln_alloc[{lk_set[p], WAY_W'(w)}]
                                     : ln_last[{lk_set[p], WAY_W'(w)}];
            end
        end

        cta_set_lookup #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W), .TIME_W(TIME_W)) u_lk (
            .way_st(g_st), .way_tag(g_tag), .way_age(g_age),
            .req_tag(lk_tag[p]), .status(lk_status[p]), .way(lk_way[p])
        );
    end

    assign pr_line  = {lk_set[0], lk_way[0]};
    assign acc_line = {lk_set[1], lk_way[1]};
    assign fa_line  = {lk_set[2], lk_way[2]};

    assign probe_set       = lk_set[0];
    assign probe_tag       = lk_tag[0];
    assign probe_status    = lk_status[0];
    assign probe_way       = lk_way[0];
    assign probe_blk       = ln_blk[pr_line];
    assign probe_fill_time = ln_fill[pr_line];
    assign acc_status      = lk_status[1];
    assign acc_way         = lk_way[1];

    // Cycle counter that timestamps allocations, accesses and fills.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    // Line state: flush, then fill by index, fill by address, access.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < LINES; i++) ln_st[i] <= LN_INVALID;
        end else if (fill_idx_valid) begin
            if (ln_st[fill_idx] == LN_PENDING) ln_st[fill_idx] <= LN_VALID;
        end else if (fill_addr_valid) begin
            if (lk_status[2] == LK_MISS || lk_status[2] == LK_HIT_PEND)
                ln_st[fa_line] <= LN_VALID;
        end else if (acc_valid && !ALLOC_ON_FILL && lk_status[1] == LK_MISS) begin
            ln_st[acc_line] <= LN_PENDING;
        end
    end

    // Line payload: tags, block addresses and timestamps, same priority.
    always_ff @(posedge clk) begin
        if (rst_n && !flush) begin
            if (fill_idx_valid) begin
                if (ln_st[fill_idx] == LN_PENDING) ln_fill[fill_idx] <= now;
            end else if (fill_addr_valid) begin
                if (lk_status[2] == LK_MISS) begin
                    ln_tag[fa_line]   <= lk_tag[2];
                    ln_blk[fa_line]   <= blk_of(fill_addr);
                    ln_alloc[fa_line] <= now;
                    ln_last[fa_line]  <= now;
                    ln_fill[fa_line]  <= now;
                end else if (lk_status[2] == LK_HIT_PEND) begin
                    ln_fill[fa_line] <= now;
                end
            end else if (acc_valid) begin
                if (lk_status[1] == LK_HIT || lk_status[1] == LK_HIT_PEND) begin
                    ln_last[acc_line] <= now;
                end else if (lk_status[1] == LK_MISS && !ALLOC_ON_FILL) begin
                    ln_tag[acc_line]   <= lk_tag[1];
                    ln_blk[acc_line]   <= blk_of(acc_addr);
                    ln_alloc[acc_line] <= now;
                    ln_last[acc_line]  <= now;
                    ln_fill[acc_line]  <= '0;
                end
            end
        end
    end

    // Access, miss and pending-hit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_access  <= '0;
            cnt_miss    <= '0;
            cnt_pending <= '0;
        end else if (acc_valid) begin
            cnt_access <= cnt_access + 1'b1;
            if (lk_status[1] != LK_HIT)      cnt_miss    <= cnt_miss + 1'b1;
            if (lk_status[1] == LK_HIT_PEND) cnt_pending <= cnt_pending + 1'b1;
        end
    end

    // Occupancy vector used by the flush check.
    always_comb begin
        for (int i = 0; i < LINES; i++) live[i] = (ln_st[i] != LN_INVALID);
    end

    // R11
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush, fill_idx_valid, fill_addr_valid, acc_valid}));

    // R6
    fill_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_idx_valid |-> ln_st[fill_idx] == LN_PENDING);

    // R6
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_idx_valid |=> ln_st[$past(fill_idx)] == LN_VALID);

    // R5
    alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ALLOC_ON_FILL && lk_status[1] == LK_MISS)
            |=> ln_st[$past(acc_line)] == LN_PENDING);

    // R11
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> live == '0);

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> cnt_access == $past(cnt_access) + 1'b1);
endmodule

// File: tb/cta_tag_array_tb.sv
module cta_tag_array_tb;
    import cta_pkg::*;

    localparam int AW = 12, NS = 4, NW = 2, LB = 16, TW = 32, CW = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz
    logic rst_n;

    // Instance A: LRU, allocate at miss time
    logic [AW-1:0] a_paddr, a_aaddr, a_faddr, a_pblk;
    logic [1:0]    a_pset;
    logic [5:0]    a_ptag;
    logic [1:0]    a_pst, a_ast;
    logic          a_pway, a_away, a_av, a_fiv, a_fav, a_fl;
    logic [2:0]    a_fi;
    logic [TW-1:0] a_pft;
    logic [CW-1:0] a_ca, a_cm, a_cp;
    // Instance B: FIFO, allocate at fill time
    logic [AW-1:0] b_paddr, b_aaddr, b_faddr, b_pblk;
    logic [1:0]    b_pset;
    logic [5:0]    b_ptag;
    logic [1:0]    b_pst, b_ast;
    logic          b_pway, b_away, b_av, b_fiv, b_fav, b_fl;
    logic [2:0]    b_fi;
    logic [TW-1:0] b_pft;
    logic [CW-1:0] b_ca, b_cm, b_cp;

    cta_tag_array #(.SETS(NS), .WAYS(NW), .LINE_BYTES(LB), .ADDR_W(AW), .TIME_W(TW),
                    .CNT_W(CW), .REPL_FIFO(1'b0), .ALLOC_ON_FILL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .probe_addr(a_paddr), .probe_set(a_pset), .probe_tag(a_ptag),
        .probe_status(a_pst), .probe_way(a_pway), .probe_blk(a_pblk), .probe_fill_time(a_pft),
        .acc_valid(a_av), .acc_addr(a_aaddr), .acc_status(a_ast), .acc_way(a_away),
        .fill_idx_valid(a_fiv), .fill_idx(a_fi), .fill_addr_valid(a_fav), .fill_addr(a_faddr),
        .flush(a_fl), .cnt_access(a_ca), .cnt_miss(a_cm), .cnt_pending(a_cp));

    cta_tag_array #(.SETS(NS), .WAYS(NW), .LINE_BYTES(LB), .ADDR_W(AW), .TIME_W(TW),
                    .CNT_W(CW), .REPL_FIFO(1'b1), .ALLOC_ON_FILL(1'b1)) u_dut_f (
        .clk(clk), .rst_n(rst_n), .probe_addr(b_paddr), .probe_set(b_pset), .probe_tag(b_ptag),
        .probe_status(b_pst), .probe_way(b_pway), .probe_blk(b_pblk), .probe_fill_time(b_pft),
        .acc_valid(b_av), .acc_addr(b_aaddr), .acc_status(b_ast), .acc_way(b_away),
        .fill_idx_valid(b_fiv), .fill_idx(b_fi), .fill_addr_valid(b_fav), .fill_addr(b_faddr),
        .flush(b_fl), .cnt_access(b_ca), .cnt_miss(b_cm), .cnt_pending(b_cp));

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [TW-1:0] tb_now;

    // Bench copy of the cycle count since reset
    always @(posedge clk) tb_now <= rst_n ? tb_now + 1 : '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int tg, input int st, input int off);
        logic [5:0] t6 = tg[5:0];
        logic [1:0] s2 = st[1:0];
        logic [3:0] o4 = off[3:0];
        return {t6, s2, o4};
    endfunction

    task automatic probe(input bit f, input logic [AW-1:0] a, input lk_t es,
                         input int ew, input string req);
        logic [1:0] st;
        logic       wy;
        @(negedge clk);
        if (f) b_paddr = a; else a_paddr = a;
        #1;
        st = f ? b_pst : a_pst;
        wy = f ? b_pway : a_pway;
        chk(st == es, req, "probe status", st, es);
        if (es != LK_FAIL) chk(wy == ew[0], req, "probe way", wy, ew);
    endtask

    task automatic info(input bit f, input logic [AW-1:0] eb, input logic [TW-1:0] et,
                        input string req);
        logic [AW-1:0] b;
        logic [TW-1:0] t;
        b = f ? b_pblk : a_pblk;
        t = f ? b_pft : a_pft;
        chk(b == eb, req, "block address", b, eb);
        chk(t == et, req, "fill time", t, et);
    endtask

    task automatic access(input bit f, input logic [AW-1:0] a, input lk_t es,
                          input int ew, input string req);
        logic [1:0] st;
        logic       wy;
        @(negedge clk);
        if (f) begin b_aaddr = a; b_av = 1'b1; end
        else   begin a_aaddr = a; a_av = 1'b1; end
        #1;
        st = f ? b_ast : a_ast;
        wy = f ? b_away : a_away;
        chk(st == es, req, "access status", st, es);
        if (es != LK_FAIL) chk(wy == ew[0], req, "access way", wy, ew);
        @(negedge clk);
        a_av = 1'b0;
        b_av = 1'b0;
    endtask

    task automatic fill_line(input logic [2:0] idx, output logic [TW-1:0] t);
        @(negedge clk);
        a_fi = idx; a_fiv = 1'b1; t = tb_now;
        @(negedge clk);
        a_fiv = 1'b0;
    endtask

    task automatic fill_blk(input logic [AW-1:0] a, output logic [TW-1:0] t);
        @(negedge clk);
        b_faddr = a; b_fav = 1'b1; t = tb_now;
        @(negedge clk);
        b_fav = 1'b0;
    endtask

    task automatic counts(input bit f, input int ea, input int em, input int ep,
                          input string req);
        @(negedge clk);
        #1;
        chk((f ? b_ca : a_ca) == CW'(ea), req, "access count", f ? b_ca : a_ca, ea);
        chk((f ? b_cm : a_cm) == CW'(em), req, "miss count", f ? b_cm : a_cm, em);
        chk((f ? b_cp : a_cp) == CW'(ep), req, "pending count", f ? b_cp : a_cp, ep);
    endtask

    initial begin
        logic [TW-1:0] t_a, t_b, t_e, t_x, t_y, t_z;
        logic [AW-1:0] ad_a, ad_b, ad_c, ad_e, ad_x, ad_y, ad_z;
        ad_a = mk(1, 0, 4); ad_b = mk(2, 0, 8); ad_c = mk(3, 0, 0); ad_e = mk(1, 2, 0);
        ad_x = mk(5, 1, 12); ad_y = mk(6, 1, 0); ad_z = mk(7, 1, 0);
        rst_n = 1'b0;
        a_paddr = '0; a_aaddr = '0; a_faddr = '0; a_av = 0; a_fiv = 0; a_fav = 0; a_fl = 0; a_fi = '0;
        b_paddr = '0; b_aaddr = '0; b_faddr = '0; b_av = 0; b_fiv = 0; b_fav = 0; b_fl = 0; b_fi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: counters cleared by reset
        counts(0, 0, 0, 0, "R2");
        counts(1, 0, 0, 0, "R2");

        // R1, R2: sweep every address through the split and the empty arrays
        for (int ad = 0; ad < (1 << AW); ad++) begin
            bit ok;
            a_paddr = AW'(ad);
            b_paddr = AW'(ad);
            #1;
            ok = (a_pset == 2'((ad >> 4) & (NS - 1))) && (a_ptag == 6'(ad >> 6));
            chk(ok, "R1", "split", {a_ptag, a_pset}, ad >> 4);
            ok = (a_pst == LK_MISS) && (a_pway == 1'b0) && (b_pst == LK_MISS) && (b_pway == 1'b0);
            chk(ok, "R2", "empty lookup", {a_pst, b_pst}, {LK_MISS, LK_MISS});
        end

        // R5: miss claims way 0, line becomes pending
        access(0, ad_a, LK_MISS, 0, "R5");
        probe(0, ad_a, LK_HIT_PEND, 0, "R5");
        counts(0, 1, 1, 0, "R10");

        // R4: holding a probe changes nothing
        for (int i = 0; i < 6; i++) probe(0, ad_b, LK_MISS, 1, "R4");
        probe(0, ad_a, LK_HIT_PEND, 0, "R4");
        counts(0, 1, 1, 0, "R4");

        // R10: pending hit counted as miss and as pending
        access(0, ad_a, LK_HIT_PEND, 0, "R10");
        counts(0, 2, 2, 1, "R10");

        // R7 lowest empty way; R8 all pending gives FAIL and no change
        access(0, ad_b, LK_MISS, 1, "R7");
        access(0, ad_c, LK_FAIL, 0, "R8");
        probe(0, ad_c, LK_FAIL, 0, "R8");
        probe(0, ad_a, LK_HIT_PEND, 0, "R8");
        probe(0, ad_b, LK_HIT_PEND, 1, "R8");
        counts(0, 4, 4, 1, "R10");

        // R6: fill by index set*WAYS+way
        fill_line(3'd0, t_a);
        probe(0, ad_a, LK_HIT, 0, "R6");
        info(0, mk(1, 0, 0), t_a, "R6");
        fill_line(3'd1, t_b);
        probe(0, ad_b, LK_HIT, 1, "R6");
        info(0, mk(2, 0, 0), t_b, "R1");

        // R3 plain hit; R7 LRU picks the way touched longest ago
        access(0, ad_a, LK_HIT, 0, "R3");
        probe(0, ad_c, LK_MISS, 1, "R7");
        access(0, ad_c, LK_MISS, 1, "R7");
        probe(0, ad_b, LK_MISS, 0, "R7");
        probe(0, ad_c, LK_HIT_PEND, 1, "R5");

        // R1: index maps a different set to line 4
        access(0, ad_e, LK_MISS, 0, "R1");
        fill_line(3'd4, t_e);
        probe(0, ad_e, LK_HIT, 0, "R1");
        info(0, ad_e, t_e, "R6");
        probe(0, ad_a, LK_HIT, 0, "R1");

        // R11: flush empties everything, counters kept
        @(negedge clk); a_fl = 1'b1;
        @(negedge clk); a_fl = 1'b0;
        probe(0, ad_a, LK_MISS, 0, "R11");
        probe(0, ad_c, LK_MISS, 0, "R11");
        probe(0, ad_e, LK_MISS, 0, "R11");
        counts(0, 7, 6, 1, "R11");

        // R9: allocation at fill time
        access(1, ad_x, LK_MISS, 0, "R9");
        probe(1, ad_x, LK_MISS, 0, "R9");
        counts(1, 1, 1, 0, "R9");
        fill_blk(ad_x, t_x);
        probe(1, ad_x, LK_HIT, 0, "R9");
        info(1, mk(5, 1, 0), t_x, "R9");
        fill_blk(ad_y, t_y);
        probe(1, ad_y, LK_HIT, 1, "R9");

        // R7 FIFO: a recent hit does not protect the oldest allocation
        access(1, ad_x, LK_HIT, 0, "R3");
        probe(1, ad_z, LK_MISS, 0, "R7");
        fill_blk(ad_z, t_z);
        probe(1, ad_z, LK_HIT, 0, "R9");
        info(1, ad_z, t_z, "R9");
        probe(1, ad_x, LK_MISS, 1, "R7");

        // R9: refill of a valid block changes nothing
        fill_blk(ad_y, t_z);
        probe(1, ad_y, LK_HIT, 1, "R9");
        info(1, ad_y, t_y, "R9");
        counts(1, 2, 1, 0, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule